// File: doc/BRIEF.md
# Coherent Byte-Update Baud Divisor Register

This block is a 16-bit control register on a simple peripheral bus. It holds a 13-bit divisor that sets a serial bit rate. The bus carries an address, 16-bit write data, two byte enables, a write strobe and combinational read data. Software may write the register one byte at a time. An upper-byte write on its own is held in a hidden staging byte, and the matching lower-byte write then commits both bytes in the same cycle. This way the divisor never holds half of an old value and half of a new one.

The block also makes a rate tick. A counter runs on the module clock and gives a one-cycle pulse once every divisor clocks. A divisor of zero stops the pulses. When the committed divisor changes, the counter starts again from zero.

Top module: `baud_div_reg`

## Requirements
- R1: Bus bit 15 is the MSB. Read bits 15:13 are always zero and writes to them are discarded. The divisor is bits 12:0.
- R2: After reset the register reads 0x0004 and the tick pulses once every 4 clocks.
- R3: A write with only `be[1]` set (bits 15:8) leaves the committed register and the `divisor` output unchanged, and stages `wdata[15:8]`.
- R4: A write with only `be[0]` set (bits 7:0) that follows a staged upper byte commits the staged byte as bits 15:8 and `wdata[7:0]` as bits 7:0 in the same clock.
- R5: A lower-only write with no staged byte loads zero into bits 15:8. Each staged byte is used at most once.
- R6: A write with both byte enables set loads both bytes from `wdata` at once and discards any staged byte.
- R7: Of several upper-only writes, the last one is committed. Reads never show the staged byte and do not discard it.
- R8: The tick is a single-cycle pulse repeating every `divisor` clocks; with divisor 0 no tick occurs.
- R9: After the committed divisor changes, no tick occurs until `divisor`+1 clocks after the write edge, at which point the first tick appears.
- R10: Writes whose address differs from `REG_ADDR`, or with both enables clear, change nothing; reads at another address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Bus address |
| wdata | input | 16 | Write data, bit 15 MSB |
| be | input | 2 | Byte enables: [1] bits 15:8, [0] bits 7:0 |
| we | input | 1 | Write strobe |
| rdata | output | 16 | Read data for `addr` |
| divisor | output | DIV_W | Committed divisor |
| tick | output | 1 | One-cycle rate pulse |

## Verification
The register is written with full words, with upper-then-lower pairs, and with lower-only writes that have no staged byte. These three patterns show a committed byte apart from a forced-zero upper byte. Patterns that interleave a read or a full word between the two halves show whether the staged byte survives a read and whether a full word discards it. The tick is measured as the interval between pulses, and again as the delay after each divisor change. Divisors 0, 1, 4 and larger values are used so that a free-running counter, a counter that is not restarted, and a counter that is not stopped can each be detected.

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
  parameter int ADDR_W = 4,
  parameter int REG_ADDR = 0,
  parameter int DIV_W = 13,
  parameter logic [15:0] RST_VAL = 16'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [1:0]        be,
  input  logic              we,
  output logic [15:0]       rdata,
  output logic [DIV_W-1:0]  divisor,
  output logic              tick
);
  localparam logic [15:0] MASK = 16'((32'h1 << DIV_W) - 1);

  logic [15:0]      value;
  logic [7:0]       stage;
  logic             pend;
  logic [DIV_W-1:0] prev_div;
  logic [DIV_W-1:0] cnt;

  wire hit    = (addr == ADDR_W'(REG_ADDR));
  wire wr     = we && hit;
  wire wr_hi  = wr && (be == 2'b10);
  wire wr_lo  = wr && (be == 2'b01);
  wire wr_all = wr && (be == 2'b11);

  assign divisor = value[DIV_W-1:0];
  assign rdata   = hit ? (value & MASK) : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= RST_VAL & MASK;
      stage <= 8'h00;
      pend  <= 1'b0;
    end else begin
      if (wr_hi) begin
        stage <= wdata[15:8];
        pend  <= 1'b1;
      end
      if (wr_lo) begin
        value <= {(pend ? stage : 8'h00), wdata[7:0]} & MASK;
        pend  <= 1'b0;
      end
      if (wr_all) begin
        value <= wdata & MASK;
        pend  <= 1'b0;
      end
    end
  end

  wire changed = (divisor != prev_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_div <= RST_VAL[DIV_W-1:0];
      cnt      <= '0;
      tick     <= 1'b0;
    end else begin
      prev_div <= divisor;
      if (divisor == '0 || changed) begin
        cnt  <= '0;
        tick <= 1'b0;
      end else if (cnt == divisor - 1'b1) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/baud_div_reg_chk.sv
module baud_div_reg_chk #(
  parameter int ADDR_W = 4,
  parameter int REG_ADDR = 0,
  parameter int DIV_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        be,
  input logic              we,
  input logic [15:0]       rdata,
  input logic [DIV_W-1:0]  divisor,
  input logic              tick
);
  wire hit = (addr == ADDR_W'(REG_ADDR));

  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rdata[15:13] == 3'b000); // R1
  AST_UPPER_ONLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (we && hit && be == 2'b10) |=> $stable(divisor)); // R3
  AST_NO_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (we && (!hit || be == 2'b00)) |=> $stable(divisor)); // R10
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (tick && divisor > 1) |=> !tick); // R8
  AST_ZERO_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) (divisor == '0) |=> !tick); // R8
  AST_CHANGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) !$stable(divisor) |=> !tick); // R9
endmodule

bind baud_div_reg baud_div_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .be(be), .we(we),
  .rdata(rdata), .divisor(divisor), .tick(tick)
);

// File: tb/baud_div_reg_tb_top.sv
`timescale 1ns/1ps
module baud_div_reg_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [1:0] be = 0;
  logic we = 0;
  logic [15:0] rdata;
  logic [12:0] divisor;
  logic tick;
  logic rd_req = 0;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  baud_div_reg dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .be(be),
                      .we(we), .rdata(rdata), .divisor(divisor), .tick(tick));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rd_req && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata, e);
      if (addr == 4'd0) check({t, " divisor"}, divisor, e[12:0]);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; we = 1;
    @(negedge clk);
    we = 0; be = 0; addr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    addr = a; rd_req = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 0; addr = 0;
  endtask

  task automatic period(input int exp, input string tag);
    int n = 0;
    int guard = 0;
    while (!tick && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk); n = 1;
    while (!tick && n < 20000) begin @(negedge clk); n++; end
    check(tag, n, exp);
  endtask

  task automatic wr_restart(input logic [15:0] d, input int dv, input string tag);
    int early = 0;
    @(negedge clk);
    addr = 0; be = 2'b11; wdata = d; we = 1;
    @(negedge clk);
    we = 0; be = 0;
    for (int n = 1; n <= dv; n++) begin
      @(negedge clk);
      if (tick) early++;
    end
    check({tag, " no early tick"}, early, 0);
    @(negedge clk);
    check({tag, " first tick"}, tick, 1);
  endtask

  initial begin
    #2000000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 16'h0004, "R2 reset value");
    period(4, "R2 reset tick period");
    wr(0, 2'b11, 16'hFFFF);
    rd(0, 16'h1FFF, "R1 top bits masked / R6 word write");
    wr(0, 2'b10, 16'h0500);
    rd(0, 16'h1FFF, "R3 upper-only holds");
    wr(0, 2'b01, 16'h0033);
    rd(0, 16'h0533, "R4 pair commit");
    wr(0, 2'b01, 16'h0044);
    rd(0, 16'h0044, "R5 no staged byte zeroes upper");
    wr(0, 2'b10, 16'h0700);
    wr(0, 2'b11, 16'h0010);
    wr(0, 2'b01, 16'h0022);
    rd(0, 16'h0022, "R6 word write discards staged byte");
    wr(0, 2'b10, 16'h0100);
    wr(0, 2'b10, 16'h0200);
    wr(0, 2'b01, 16'h0007);
    rd(0, 16'h0207, "R7 last upper wins");
    wr(0, 2'b10, 16'h0300);
    rd(0, 16'h0207, "R7 staged byte invisible");
    wr(0, 2'b01, 16'h0040);
    rd(0, 16'h0340, "R7 read keeps staged byte");
    wr(0, 2'b10, 16'hFF00);
    wr(0, 2'b01, 16'h0001);
    rd(0, 16'h1F01, "R1 staged top bits masked");
    wr(4'd3, 2'b11, 16'h0123);
    rd(0, 16'h1F01, "R10 other address ignored");
    wr(0, 2'b00, 16'h0123);
    rd(0, 16'h1F01, "R10 no enable ignored");
    rd(4'd3, 16'h0000, "R10 other address reads zero");
    wr_restart(16'h0006, 6, "R9 div 6");
    period(6, "R8 period 6");
    wr_restart(16'h0003, 3, "R9 div 3");
    period(3, "R8 period 3");
    wr_restart(16'h0001, 1, "R9 div 1");
    period(1, "R8 period 1");
    wr(0, 2'b11, 16'h0000);
    begin
      int seen = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (tick) seen++;
      end
      check("R8 zero divisor no ticks", seen, 0);
    end
    wr_restart(16'h0010, 16, "R9 div 16");
    period(16, "R8 period 16");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule